// File: doc/BRIEF.md
# I2C bus recovery sequencer

This block frees an I2C bus that a slave device has left in a stuck state. This typically happens when the slave was reset or interrupted partway through a byte and is still pulling SDA low. The block works directly on the two open-drain wires. Each of its outputs is a pull-down enable: 1 pulls the line low, and 0 lets the external pull-up take it high. The block never drives a line high, so a slave can always hold SCL low to stretch the clock.

A single-cycle request starts a sequence with these steps:

1. Release both lines and wait a long settle time.
2. Give up at once if SCL is held low.
3. While SDA is low, toggle SCL with bounded low and high phases. After each release, wait out any clock stretching within a bounded polling window.
4. When SDA reads high, pull SDA low (a START) and then release it (a STOP), so every slave returns to idle.

The outcome is a 2-bit code, and completion is flagged by a one-cycle done pulse. Every duration is a parameter counted in clock cycles. Both line inputs pass through two-flop synchronizers before any decision uses them.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, busy_o, done_o, scl_pull_o and sda_pull_o are 0 and result_o is 2'b00.
- R2: A start_i pulse while idle raises busy_o on the next clock edge. Both lines then stay released for at least SETTLE_CYC cycles before either pull output rises.
- R3: If the synchronized SCL reads low at the end of the settle interval, the run ends with result 2'b01 and no SCL or SDA pull is made.
- R4: While the synchronized SDA reads low, the block pulls SCL low for HALF_CYC cycles and then releases it for HALF_CYC cycles. HALF_CYC must exceed the synchronizer latency. SDA is re-sampled after every pulse, and pulsing stops as soon as SDA reads high.
- R5: After each SCL release, SCL is checked once and then re-checked up to POLL_MAX more times, POLL_CYC cycles apart. A stretch shorter than this window lets the run continue. If SCL is still low at the last check, the run ends with result 2'b10.
- R6: If SDA is still low after PULSE_MAX pulses, the run ends with result 2'b11 after exactly PULSE_MAX pulses.
- R7: When SDA reads high, the block pulls SDA low for HALF_CYC cycles while SCL is released, then releases SDA and waits HALF_CYC cycles. The run then ends with result 2'b00 and exactly one SDA pull.
- R8: scl_pull_o and sda_pull_o are never 1 in the same cycle, and both are 0 whenever busy_o is 0.
- R9: done_o is a one-cycle pulse, raised on the same edge where busy_o falls. result_o changes only in the done cycle and holds its value afterwards.
- R10: start_i pulses while busy_o is 1 are ignored. The run finishes normally, and no new run starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Recovery request, sampled while idle |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| scl_pull_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | A recovery run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| result_o | output | 2 | 00 ok, 01 SCL stuck, 10 stretch timeout, 11 SDA stuck |

## Verification
The bench models the bus as wired-AND lines that combine the block's pulls with a simulated slave. It tries the following patterns:

- **Idle bus.** Shows that a healthy bus gets only a START/STOP and no clock pulses.
- **SCL held low from the start.** Separates the immediate 01 exit from any pulsing.
- **SDA released after a few pulses.** Confirms the pulse count stops at the first high SDA sample.
- **SDA never released.** Reaches the pulse budget and the 11 code.
- **Clock stretching, short.** A stretch after each release that ends inside the poll window must not abort the run.
- **Clock stretching, unending.** A stretch that never ends must give the 10 code after one pulse.

A final run sends extra requests while busy and confirms that they start nothing.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;

  typedef enum logic [1:0] {
    RES_OK          = 2'd0,
    RES_SCL_STUCK   = 2'd1,
    RES_STRETCH_TMO = 2'd2,
    RES_SDA_STUCK   = 2'd3
  } res_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_PULL_SCL,
    ST_REL_SCL,
    ST_POLL_CHK,
    ST_POLL_WAIT,
    ST_START_HOLD,
    ST_STOP_HOLD
  } st_e;

endpackage

// File: rtl/unstick_sync.sv
module unstick_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], d_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q <= '1;
      end else begin
        sh_q <= sh_d;
      end
    end

    assign q_o[g] = sh_q[STAGES-1];
  end

endmodule

// File: rtl/unstick_timer.sv
module unstick_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) begin
      cnt_d = val_i;
    end else begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
  import bus_unstick_pkg::*;
#(
  parameter int unsigned TW         = 8,
  parameter int unsigned SETTLE_CYC = 40,
  parameter int unsigned HALF_CYC   = 6,
  parameter int unsigned POLL_CYC   = 10,
  parameter int unsigned POLL_MAX   = 4,
  parameter int unsigned PULSE_MAX  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          scl_s_i,
  input  logic          sda_s_i,
  input  logic          tmr_expired_i,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          scl_pull_o,
  output logic          sda_pull_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o
);

  localparam int unsigned PW = $clog2(PULSE_MAX + 1);
  localparam int unsigned QW = $clog2(POLL_MAX + 1);
  localparam logic [TW-1:0] SETTLE_V = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] HALF_V   = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] POLL_V   = TW'(POLL_CYC - 1);

  st_e           st_q, st_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic [QW-1:0] poll_q, poll_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  res_e          res_q, res_d;
  logic          sclp_q, sdap_q;
  logic          decide, fin;
  res_e          code;

  always_comb begin
    st_d       = st_q;
    pulse_d    = pulse_q;
    poll_d     = poll_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    decide     = 1'b0;
    fin        = 1'b0;
    code       = RES_OK;

    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d       = ST_SETTLE;
          tmr_load_o = 1'b1;
          tmr_val_o  = SETTLE_V;
          pulse_d    = '0;
        end
      end
      ST_SETTLE: begin
        if (tmr_expired_i) begin
          if (!scl_s_i) begin
            fin  = 1'b1;
            code = RES_SCL_STUCK;
          end else begin
            decide = 1'b1;
          end
        end
      end
      ST_PULL_SCL: begin
        if (tmr_expired_i) begin
          st_d       = ST_REL_SCL;
          tmr_load_o = 1'b1;
          tmr_val_o  = HALF_V;
        end
      end
      ST_REL_SCL: begin
        if (tmr_expired_i) begin
          st_d   = ST_POLL_CHK;
          poll_d = '0;
        end
      end
      ST_POLL_CHK: begin
        if (scl_s_i) begin
          decide = 1'b1;
        end else if (poll_q == QW'(POLL_MAX)) begin
          fin  = 1'b1;
          code = RES_STRETCH_TMO;
        end else begin
          st_d       = ST_POLL_WAIT;
          tmr_load_o = 1'b1;
          tmr_val_o  = POLL_V;
          poll_d     = poll_q + QW'(1);
        end
      end
      ST_POLL_WAIT: begin
        if (tmr_expired_i) begin
          st_d = ST_POLL_CHK;
        end
      end
      ST_START_HOLD: begin
        if (tmr_expired_i) begin
          st_d       = ST_STOP_HOLD;
          tmr_load_o = 1'b1;
          tmr_val_o  = HALF_V;
        end
      end
      ST_STOP_HOLD: begin
        if (tmr_expired_i) begin
          fin  = 1'b1;
          code = RES_OK;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (decide) begin
      if (sda_s_i) begin
        st_d       = ST_START_HOLD;
        tmr_load_o = 1'b1;
        tmr_val_o  = HALF_V;
      end else if (pulse_q == PW'(PULSE_MAX)) begin
        fin  = 1'b1;
        code = RES_SDA_STUCK;
      end else begin
        st_d       = ST_PULL_SCL;
        tmr_load_o = 1'b1;
        tmr_val_o  = HALF_V;
        pulse_d    = pulse_q + PW'(1);
      end
    end

    if (fin) begin
      st_d = ST_IDLE;
    end
  end

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    res_d  = res_q;
    if (st_q == ST_IDLE && start_i) begin
      busy_d = 1'b1;
    end
    if (fin) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      res_d  = code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pulse_q <= '0;
      poll_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
      sclp_q  <= 1'b0;
      sdap_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= pulse_d;
      poll_q  <= poll_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      res_q   <= res_d;
      sclp_q  <= (st_d == ST_PULL_SCL);
      sdap_q  <= (st_d == ST_START_HOLD);
    end
  end

  assign scl_pull_o = sclp_q;
  assign sda_pull_o = sdap_q;
  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign result_o   = res_q;

endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
  parameter int unsigned SETTLE_CYC = 250_000_000,
  parameter int unsigned HALF_CYC   = 1_000,
  parameter int unsigned POLL_CYC   = 10_000_000,
  parameter int unsigned POLL_MAX   = 20,
  parameter int unsigned PULSE_MAX  = 20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull_o,
  output logic       sda_pull_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] result_o
);

  localparam int unsigned MAX_SP = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int unsigned MAX_D  = (MAX_SP > HALF_CYC) ? MAX_SP : HALF_CYC;
  localparam int unsigned TW     = $clog2(MAX_D + 1);

  logic [1:0]    line_s;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_expired;

  unstick_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sda_i, scl_i}),
    .q_o   (line_s)
  );

  unstick_timer #(.W(TW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (tmr_load),
    .val_i     (tmr_val),
    .expired_o (tmr_expired)
  );

  unstick_fsm #(
    .TW         (TW),
    .SETTLE_CYC (SETTLE_CYC),
    .HALF_CYC   (HALF_CYC),
    .POLL_CYC   (POLL_CYC),
    .POLL_MAX   (POLL_MAX),
    .PULSE_MAX  (PULSE_MAX)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .scl_s_i       (line_s[0]),
    .sda_s_i       (line_s[1]),
    .tmr_expired_i (tmr_expired),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .scl_pull_o    (scl_pull_o),
    .sda_pull_o    (sda_pull_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .result_o      (result_o)
  );

endmodule

// File: rtl/unstick_chk.sv
module unstick_chk #(
  parameter int unsigned SETTLE_CYC = 40,
  parameter int unsigned HALF_CYC   = 6,
  parameter int unsigned PULSE_MAX  = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_pull_o,
  input logic       sda_pull_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] result_o
);

  logic [31:0] since_q;
  logic [31:0] low_q;
  logic [31:0] npulse_q;
  logic        sclp_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q     <= '0;
      low_q       <= '0;
      npulse_q    <= '0;
      sclp_prev_q <= 1'b0;
    end else begin
      sclp_prev_q <= scl_pull_o;
      if (!busy_o) begin
        since_q <= '0;
      end else if (since_q < SETTLE_CYC) begin
        since_q <= since_q + 32'd1;
      end
      if (scl_pull_o) begin
        low_q <= low_q + 32'd1;
      end else begin
        low_q <= '0;
      end
      if (!busy_o) begin
        npulse_q <= '0;
      end else if (scl_pull_o && !sclp_prev_q) begin
        npulse_q <= npulse_q + 32'd1;
      end
    end
  end

  // R2
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && since_q < SETTLE_CYC) |-> (!scl_pull_o && !sda_pull_o));

  // R4
  pulse_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclp_prev_q && !scl_pull_o) |-> (low_q >= HALF_CYC));

  // R6
  pulse_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    npulse_q <= PULSE_MAX);

  // R8
  no_dual_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_pull_o, sda_pull_o}));

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_pull_o && !sda_pull_o));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $fell(busy_o)));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));

endmodule

bind i2c_bus_unstick unstick_chk #(
  .SETTLE_CYC (SETTLE_CYC),
  .HALF_CYC   (HALF_CYC),
  .PULSE_MAX  (PULSE_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_pull_o (scl_pull_o),
  .sda_pull_o (sda_pull_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/i2c_bus_unstick_tb.sv
module i2c_bus_unstick_tb;

  localparam int SETTLE = 40;
  localparam int HALF   = 6;
  localparam int PCYC   = 10;
  localparam int PMAX   = 4;
  localparam int NPULSE = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       scl_pull, sda_pull, busy, done;
  logic [1:0] result;
  logic       scl_line, sda_line;

  int n_chk = 0;
  int n_fail = 0;

  int  pulses, starts, sda_need, str_len, str_cnt, quiet, min_low, low_run;
  bit  scl_stuck, acted, both_seen, sclp_prev, sdap_prev;

  always #5 clk = ~clk;

  assign scl_line = !(scl_pull || scl_stuck || (str_cnt > 0));
  assign sda_line = !(sda_pull || (pulses < sda_need));

  i2c_bus_unstick #(
    .SETTLE_CYC (SETTLE), .HALF_CYC (HALF), .POLL_CYC (PCYC),
    .POLL_MAX (PMAX), .PULSE_MAX (NPULSE), .SYNC_STAGES (2)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i),
    .scl_i (scl_line), .sda_i (sda_line),
    .scl_pull_o (scl_pull), .sda_pull_o (sda_pull),
    .busy_o (busy), .done_o (done), .result_o (result)
  );

  always @(negedge clk) begin
    if (scl_pull && !sclp_prev) pulses++;
    if (sda_pull && !sdap_prev) starts++;
    if (scl_pull && sda_pull) both_seen = 1'b1;
    if (scl_pull || sda_pull) acted = 1'b1;
    if (busy && !acted) quiet++;
    if (scl_pull) low_run++;
    else begin
      if (sclp_prev && low_run < min_low) min_low = low_run;
      low_run = 0;
    end
    if (scl_pull && str_len > 0) str_cnt = str_len;
    else if (str_cnt > 0) str_cnt--;
    sclp_prev = scl_pull;
    sdap_prev = sda_pull;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  task automatic run_case(input string req, input int need, input bit stuck,
                          input int slen, input int exp_code, input int exp_pulses,
                          input int exp_starts, input bit mid_start);
    bit seen;
    @(negedge clk);
    pulses = 0; starts = 0; sda_need = need; scl_stuck = stuck;
    str_len = slen; str_cnt = 0; quiet = 0; acted = 1'b0;
    min_low = 1000000; low_run = 0; both_seen = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    if (mid_start) begin
      repeat (SETTLE + 10) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_done(seen);
    chk(seen, {req, " done seen"}, int'(seen), 1);
    chk(result == 2'(exp_code), {req, " result"}, int'(result), exp_code);
    chk(pulses == exp_pulses, {req, " SCL pulses"}, pulses, exp_pulses);
    chk(starts == exp_starts, {req, " SDA pulls (R7)"}, starts, exp_starts);
    chk(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
    chk(!both_seen, "R8 no dual pull", int'(both_seen), 0);
    if (exp_pulses + exp_starts > 0)
      chk(quiet >= SETTLE, "R2 settle quiet", quiet, SETTLE);
    if (exp_pulses > 0)
      chk(min_low >= HALF, "R4 pulse low width", min_low, HALF);
    @(negedge clk);
    chk(done == 1'b0, "R9 done single cycle", int'(done), 0);
    repeat (8) @(negedge clk);
    chk(busy == 1'b0, "R10 no new run", int'(busy), 0);
    chk(result == 2'(exp_code), "R9 result held", int'(result), exp_code);
    scl_stuck = 1'b0; str_len = 0; str_cnt = 0; sda_need = 0;
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", int'(busy), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(!scl_pull && !sda_pull, "R1 pulls", int'({scl_pull, sda_pull}), 0);
    chk(result == 2'b00, "R1 result", int'(result), 0);
  endtask

  initial begin
    pulses = 0; starts = 0; sda_need = 0; str_len = 0; str_cnt = 0;
    scl_stuck = 1'b0; sclp_prev = 1'b0; sdap_prev = 1'b0;
    min_low = 1000000; low_run = 0; quiet = 0; acted = 1'b0; both_seen = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R7 clean bus: START/STOP only
    run_case("R7 clean bus", 0, 1'b0, 0, 0, 0, 1, 1'b0);
    // R3 SCL stuck low
    run_case("R3 SCL stuck", 0, 1'b1, 0, 1, 0, 0, 1'b0);
    // R4 SDA freed after 3 pulses
    run_case("R4 SDA frees", 3, 1'b0, 0, 0, 3, 1, 1'b0);
    // R6 SDA never freed
    run_case("R6 SDA stuck", 1000, 1'b0, 0, 3, NPULSE, 0, 1'b0);
    // R5 short stretch survives
    run_case("R5 short stretch", 2, 1'b0, 25, 0, 2, 1, 1'b0);
    // R5 endless stretch times out
    run_case("R5 stretch timeout", 1000, 1'b0, 1000000, 2, 1, 0, 1'b0);
    // R10 request during busy ignored
    run_case("R10 start while busy", 2, 1'b0, 0, 0, 2, 1, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule